// File: doc/BRIEF.md
# Edge Phase Comparator with Lock Detect

This block closes the digital half of a motor speed loop. It compares a reference clock with a tachometer pulse taken from one Hall phase of the motor. A falling reference edge that arrives before the tachometer rises means the rotor lags, so the block emits an accelerate pulse. A rising tachometer edge that arrives first means the rotor leads, so the block emits a decelerate (reverse-torque braking) pulse. Each pulse lasts exactly as long as the two edges are apart, so the duty of the pulse train follows the phase error. In regulation the tachometer frequency equals the reference frequency.

The block also qualifies lock over a slow timebase. Each completed comparison that falls inside a programmable dead-zone window marks the current timebase interval as good. The lock flag rises only after a fixed number of good intervals in a row, which hides the hunting that happens during pull-in. Any excursion outside the window drops the flag at once. A gain-select output follows the lock flag, so the analog loop can run at about half gain when locked and at full gain when unlocked, in both directions. A run enable freezes everything in its inactive state.

Top module: `edge_phase_cmp`

## Requirements
- R1: A falling edge on `ref_in`, with no pulse pending, raises `up`. The next rising edge on `fg_in` ends it. `up` stays high for exactly as many clock cycles as the two input transitions are apart, and `up` and `dn` are never high together.
- R2: A rising edge on `fg_in`, with no pulse pending, raises `dn`. The next falling edge on `ref_in` ends it. `dn` stays high for exactly as many clock cycles as the two transitions are apart.
- R3: A falling `ref_in` edge and a rising `fg_in` edge in the same cycle produce no pulse.
- R4: Rising edges of `ref_in` and falling edges of `fg_in` have no effect on `up` or `dn`.
- R5: Once a pulse has lasted `dz_win` cycles, the comparison counts as out of window. `locked` falls on the next clock edge and the qualification count restarts. A comparison shorter than `dz_win` cycles counts as in window; coincident edges count as a width of 0.
- R6: `locked` rises only on a `tick` cycle. It rises on the 7th consecutive qualifying tick (LOCK_TICKS = 7). A tick qualifies when at least one in-window comparison has completed since the previous tick and no out-of-window condition is present.
- R7: A tick with no in-window comparison since the previous tick clears `locked` and restarts the count.
- R8: `gain_lo` is 1 (half loop gain) exactly while `locked` is 1, and 0 (full gain) otherwise.
- R9: While `run` is 0, `up`, `dn`, `locked` and `gain_lo` are 0 in the same cycle, and the pulse and lock state are cleared. After `run` returns, lock again needs 7 qualifying ticks.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Run enable; 0 forces outputs inactive and clears state |
| ref_in | input | 1 | Reference clock; its falling edges are compared |
| fg_in | input | 1 | Tachometer from one Hall phase; its rising edges are compared |
| tick | input | 1 | One-cycle strobe of the slow lock-qualification timebase |
| dz_win | input | DZ_W | Dead-zone window in system clocks |
| up | output | 1 | Accelerate pulse |
| dn | output | 1 | Decelerate (braking) pulse |
| locked | output | 1 | Qualified lock flag |
| gain_lo | output | 1 | 1 selects reduced (locked) loop gain |

## Verification
The bench measures pulse widths across a spread of edge separations in both orders, including coincident edges. A design that counted the wrong number of register stages, or that swapped the compared polarities, would report widths off by one or raise a pulse on a restoring transition. It walks the lock flag through the boundary between the sixth and seventh good tick, and through pulses one cycle either side of the window. A premature flag, or one that survives a pulse exactly `dz_win` wide, shows up at the port. Ticks with no comparison behind them, and dropping `run` in the middle of a pulse, are also exercised. These catch a qualifier that counts idle intervals, and one that keeps its count or its pulse across a stop.

// File: rtl/edge_phase_cmp.sv
module edge_phase_cmp #(
  parameter int DZ_W       = 8,
  parameter int LOCK_TICKS = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ref_in,
  input  logic            fg_in,
  input  logic            tick,
  input  logic [DZ_W-1:0] dz_win,
  output logic            up,
  output logic            dn,
  output logic            locked,
  output logic            gain_lo
);
  localparam int LC_W = $clog2(LOCK_TICKS + 1);
  localparam logic [DZ_W-1:0] CNT_MAX = '1;
  localparam logic [LC_W-1:0] LC_FULL = LC_W'(LOCK_TICKS);

  logic            ref_s, ref_d, fg_s, fg_d;
  logic            up_q, dn_q, locked_q, seen_ok;
  logic [DZ_W-1:0] err_cnt;
  logic [LC_W-1:0] lock_cnt;

  wire ref_fall = run & ref_d & ~ref_s;
  wire fg_rise  = run & fg_s & ~fg_d;
  wire busy     = up_q | dn_q;
  wire close_ev = (up_q & fg_rise) | (dn_q & ref_fall);
  wire both     = ref_fall & fg_rise & ~busy;
  wire good_now = (close_ev & (err_cnt < dz_win)) | (both & (dz_win != '0));
  wire unlock   = busy & (err_cnt >= dz_win);
  wire qual     = tick & ~unlock & (seen_ok | good_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_s <= 1'b0;
      ref_d <= 1'b0;
      fg_s  <= 1'b0;
      fg_d  <= 1'b0;
    end else begin
      ref_s <= ref_in;
      ref_d <= ref_s;
      fg_s  <= fg_in;
      fg_d  <= fg_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      err_cnt <= '0;
    end else if (!run) begin
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      err_cnt <= '0;
    end else if (busy) begin
      if (close_ev) begin
        up_q    <= 1'b0;
        dn_q    <= 1'b0;
        err_cnt <= '0;
      end else if (err_cnt != CNT_MAX) begin
        err_cnt <= err_cnt + DZ_W'(1);
      end
    end else if (!both) begin
      if (ref_fall) begin
        up_q    <= 1'b1;
        err_cnt <= DZ_W'(1);
      end else if (fg_rise) begin
        dn_q    <= 1'b1;
        err_cnt <= DZ_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_ok  <= 1'b0;
      lock_cnt <= '0;
      locked_q <= 1'b0;
    end else if (!run) begin
      seen_ok  <= 1'b0;
      lock_cnt <= '0;
      locked_q <= 1'b0;
    end else begin
      if (tick)
        seen_ok <= 1'b0;
      else if (good_now)
        seen_ok <= 1'b1;

      if (unlock || (tick && !qual)) begin
        lock_cnt <= '0;
        locked_q <= 1'b0;
      end else if (qual) begin
        if (lock_cnt != LC_FULL)
          lock_cnt <= lock_cnt + LC_W'(1);
        if (lock_cnt >= LC_FULL - LC_W'(1))
          locked_q <= 1'b1;
      end
    end
  end

  assign up      = up_q & run;
  assign dn      = dn_q & run;
  assign locked  = locked_q & run;
  assign gain_lo = locked;
endmodule

// File: rtl/edge_phase_cmp_chk.sv
module edge_phase_cmp_chk #(
  parameter int DZ_W = 8,
  parameter int LC_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic            tick,
  input logic [DZ_W-1:0] dz_win,
  input logic            up_q,
  input logic            dn_q,
  input logic [DZ_W-1:0] err_cnt,
  input logic            locked_q,
  input logic [LC_W-1:0] lock_cnt,
  input logic            ref_fall,
  input logic            fg_rise,
  input logic            seen_ok,
  input logic            good_now
);
  assert_updn_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q));

  assert_coincident_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ref_fall && fg_rise && !up_q && !dn_q) |=> (!up_q && !dn_q));

  assert_window_unlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((up_q || dn_q) && err_cnt >= dz_win) |=> !locked_q);

  assert_lock_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(tick));

  assert_empty_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !seen_ok && !good_now) |=> !locked_q);

  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!up_q && !dn_q && !locked_q && lock_cnt == '0));
endmodule

bind edge_phase_cmp edge_phase_cmp_chk #(.DZ_W(DZ_W), .LC_W(LC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .tick     (tick),
  .dz_win   (dz_win),
  .up_q     (up_q),
  .dn_q     (dn_q),
  .err_cnt  (err_cnt),
  .locked_q (locked_q),
  .lock_cnt (lock_cnt),
  .ref_fall (ref_fall),
  .fg_rise  (fg_rise),
  .seen_ok  (seen_ok),
  .good_now (good_now)
);

// File: tb/sim_edge_phase_cmp.sv
`timescale 1ns/1ps
module sim_edge_phase_cmp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       ref_in = 1'b1;
  logic       fg_in = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] dz_win = 8'd4;
  logic       up, dn, locked, gain_lo;

  int total = 0;
  int fails = 0;
  int m_cnt = 0;
  bit m_seen = 1'b0;
  bit m_lock = 1'b0;

  always #5 clk = ~clk;

  edge_phase_cmp u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .ref_in(ref_in), .fg_in(fg_in),
    .tick(tick), .dz_win(dz_win), .up(up), .dn(dn), .locked(locked), .gain_lo(gain_lo)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_good(int d, int dz);
    return d < dz;
  endfunction

  function automatic bit is_unlock(int d, int dz);
    return (d > 0) && (d >= dz);
  endfunction

  task automatic model_tick();
    if (m_seen) begin
      if (m_cnt < 7) m_cnt++;
      m_lock = (m_cnt >= 7);
    end else begin
      m_cnt = 0;
      m_lock = 1'b0;
    end
    m_seen = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    model_tick();
  endtask

  task automatic period(int d, bit fg_first, bit tk);
    int nu = 0;
    int nd = 0;
    @(negedge clk);
    if (fg_first) fg_in = 1'b1; else ref_in = 1'b0;
    if (d == 0) begin
      ref_in = 1'b0;
      fg_in = 1'b1;
    end
    for (int i = 1; i <= d + 4; i++) begin
      @(negedge clk);
      nu += int'(up);
      nd += int'(dn);
      if (i == d) begin
        if (fg_first) ref_in = 1'b0; else fg_in = 1'b1;
      end
    end
    if (d == 0) begin
      chk("R3 up", nu, 0);
      chk("R3 dn", nd, 0);
    end else if (fg_first) begin
      chk("R2 dn width", nd, d);
      chk("R2 up idle", nu, 0);
    end else begin
      chk("R1 up width", nu, d);
      chk("R1 dn idle", nd, 0);
    end
    ref_in = 1'b1;
    fg_in = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4 restore ignored", int'(up | dn), 0);
    end
    if (is_unlock(d, int'(dz_win))) begin
      m_cnt = 0;
      m_lock = 1'b0;
    end
    if (is_good(d, int'(dz_win))) m_seen = 1'b1;
    if (tk) pulse_tick();
    chk("R5/R6 locked", int'(locked), int'(m_lock));
    chk("R8 gain_lo", int'(gain_lo), int'(m_lock));
  endtask

  initial begin
    #2_000_000;
    total++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    chk("R10 up", int'(up), 0);
    chk("R10 dn", int'(dn), 0);
    chk("R10 locked", int'(locked), 0);
    chk("R10 gain_lo", int'(gain_lo), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;
    repeat (3) @(negedge clk);

    dz_win = 8'd4;
    for (int k = 0; k < 6; k++) period(1 + (k % 3), k[0], 1'b1);
    chk("R6 not yet after six", int'(locked), 0);
    period(2, 1'b0, 1'b1);
    chk("R6 lock at seventh", int'(locked), 1);

    period(3, 1'b1, 1'b0);
    chk("R5 width dz-1 keeps lock", int'(locked), 1);
    period(4, 1'b0, 1'b0);
    chk("R5 width dz drops lock", int'(locked), 0);

    for (int k = 0; k < 7; k++) period(1, 1'b1, 1'b1);
    chk("R6 relocked", int'(locked), 1);
    pulse_tick();
    chk("R7 empty tick", int'(locked), 0);
    chk("R8 gain after empty tick", int'(gain_lo), 0);

    dz_win = 8'd0;
    period(0, 1'b0, 1'b1);
    chk("R5 zero window coincident", int'(locked), 0);
    dz_win = 8'd4;
    period(0, 1'b1, 1'b1);

    for (int k = 0; k < 7; k++) period(2, 1'b0, 1'b1);
    chk("R9 locked before stop", int'(locked), 1);
    @(negedge clk) ref_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 pulse before stop", int'(up), 1);
    run = 1'b0;
    #1;
    chk("R9 up forced", int'(up), 0);
    chk("R9 locked forced", int'(locked), 0);
    chk("R9 gain forced", int'(gain_lo), 0);
    @(negedge clk) fg_in = 1'b1;
    repeat (2) @(negedge clk);
    ref_in = 1'b1;
    fg_in = 1'b0;
    repeat (3) @(negedge clk);
    run = 1'b1;
    m_cnt = 0;
    m_seen = 1'b0;
    m_lock = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 no pulse after restart", int'(up | dn), 0);
    period(1, 1'b0, 1'b1);
    chk("R9 count restarted", int'(locked), 0);

    dz_win = 8'd5;
    for (int k = 0; k < 80; k++) begin
      int d = int'($urandom_range(0, 8));
      if ($urandom_range(0, 3) != 0) d = int'($urandom_range(0, 3));
      period(d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule